// File: doc/BRIEF.md
# Prefetching Sequential Read Unit

This unit sits between a kernel datapath and a global memory read port. It keeps a local FIFO filled with the words that follow the most recently consumed address. It does this by issuing fixed-length burst reads ahead of demand, assuming the consumer walks memory in increasing word order. A read request whose address equals the predicted next address is served straight from the FIFO head. The answer appears one cycle after the request is accepted.

A read to any other address is still correct, but it costs a refill. The unit throws away the FIFO contents and moves the fetch pointer to the requested address. Words that are still returning from bursts issued before the jump are counted and discarded. A start pulse does the same thing without a pending request, so prefetching can begin before the first read arrives. The memory region is treated as read-only, so data held in the FIFO is never invalidated.

Memory addresses are word addresses. Each burst request asks for `BURST` consecutive words starting at `mem_req_addr_o`. The memory returns those words in issue order, one per `mem_rsp_valid_i` pulse. `DEPTH` must be a power of two and at least `2*BURST`.

Top module: `pf_read_unit`

## Requirements
- R1: Out of reset, `rsp_valid_o` and `req_ready_o` are low, and the first burst requested starts at word address `RESET_ADDR` (default 0).
- R2: A request whose address equals the predicted head address, made while the FIFO holds data, is accepted in the same cycle. One cycle later `rsp_valid_o` is high and `rsp_data_o` carries the memory word at that address.
- R3: `mem_req_valid_o` is high exactly when DEPTH minus (words held in the FIFO plus words requested from memory but not yet returned) is at least BURST. Held plus in-flight words never exceed DEPTH.
- R4: `req_ready_o` is low whenever the FIFO is empty, and also while `start_i` is high.
- R5: A request to an address other than the predicted head empties the FIFO in that cycle and is not accepted in that cycle. The next burst requested starts at the requested address, and the request is accepted once that word has arrived.
- R6: Words returning from bursts issued before a flush are discarded and never reach `rsp_data_o`. This includes a burst accepted by memory in the flush cycle itself and a word arriving in the flush cycle.
- R7: While no flush occurs, consecutive burst requests carry addresses that step by BURST. A `start_i` pulse empties the FIFO and restarts fetching at `start_addr_i`, and it takes priority over a request made in the same cycle.
- R8: Each accepted request yields exactly one response, in acceptance order. After an acceptance the predicted head address advances by one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Flush and restart prefetch at `start_addr_i` |
| start_addr_i | input | AW | Restart word address |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | AW | Read request word address |
| req_ready_o | output | 1 | Request accepted this cycle |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | DW | Read response data |
| mem_req_valid_o | output | 1 | Burst request valid |
| mem_req_addr_o | output | AW | Burst start word address |
| mem_req_ready_i | input | 1 | Memory accepts the burst request |
| mem_rsp_valid_i | input | 1 | One returned burst word valid |
| mem_rsp_data_i | input | DW | Returned burst word |

## Verification
Every cycle, the assertions check the occupancy bound, and that the FIFO is neither overrun nor read while empty. They also check that a flush leaves the FIFO empty, that acceptance is followed by a response, and that the head address steps by one. Whether the returned data belongs to the right address, and whether stale bursts are really dropped after a jump or a restart, can only be shown by the bench's scenarios. Those scenarios include misses while slow bursts are still in flight, and a restart that coincides with a request. The bench's word-level memory model tags each burst with a flush epoch to make this check.

// File: rtl/pf_read_pkg.sv
package pf_read_pkg;
  localparam int unsigned DEF_AW    = 32;
  localparam int unsigned DEF_DW    = 32;
  localparam int unsigned DEF_DEPTH = 64;
  localparam int unsigned DEF_BURST = 16;
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int unsigned DW    = pf_read_pkg::DEF_DW,
  parameter int unsigned DEPTH = pf_read_pkg::DEF_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  assign pop_data_o = mem_q[rd_ptr_q];
  assign count_o    = cnt_q;
  assign empty_o    = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> (cnt_q < CW'(DEPTH)));
  p_no_pop_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pf_fetch_ctrl.sv
module pf_fetch_ctrl #(
  parameter int unsigned AW         = pf_read_pkg::DEF_AW,
  parameter int unsigned DEPTH      = pf_read_pkg::DEF_DEPTH,
  parameter int unsigned BURST      = pf_read_pkg::DEF_BURST,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int unsigned CW        = $clog2(DEPTH + 1),
  localparam int unsigned UW        = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic [CW-1:0] fifo_count_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  output logic          push_o
);
  logic [AW-1:0] fetch_q, fetch_d;
  logic [CW-1:0] live_q, live_d;   // words in flight that will be kept
  logic [CW-1:0] drop_q, drop_d;   // words in flight that will be discarded
  logic [UW-1:0] used;
  logic          issue, rsp_live, rsp_stale;
  logic [CW-1:0] burst_add;

  assign used            = UW'(fifo_count_i) + UW'(live_q) + UW'(drop_q);
  assign mem_req_valid_o = (used <= UW'(DEPTH - BURST));
  assign mem_req_addr_o  = fetch_q;
  assign issue           = mem_req_valid_o && mem_req_ready_i;
  assign burst_add       = issue ? CW'(BURST) : '0;
  // returns are in order, so stale words always precede live ones
  assign rsp_stale       = mem_rsp_valid_i && (drop_q != '0);
  assign rsp_live        = mem_rsp_valid_i && (drop_q == '0);
  assign push_o          = rsp_live && !flush_i;

  always_comb begin
    if (flush_i) begin
      drop_d  = drop_q - CW'(rsp_stale) + live_q - CW'(rsp_live) + burst_add;
      live_d  = '0;
      fetch_d = flush_addr_i;
    end else begin
      drop_d  = drop_q - CW'(rsp_stale);
      live_d  = live_q + burst_add - CW'(rsp_live);
      fetch_d = issue ? fetch_q + AW'(BURST) : fetch_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= RESET_ADDR;
      live_q  <= '0;
      drop_q  <= '0;
    end else begin
      fetch_q <= fetch_d;
      live_q  <= live_d;
      drop_q  <= drop_d;
    end
  end

  p_occupancy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= UW'(DEPTH));
  p_burst_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && !flush_i) |=> (mem_req_addr_o == $past(mem_req_addr_o) + AW'(BURST)));
  p_flush_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (mem_req_addr_o == $past(flush_addr_i)));
endmodule

// File: rtl/pf_read_unit.sv
module pf_read_unit #(
  parameter int unsigned AW           = pf_read_pkg::DEF_AW,
  parameter int unsigned DW           = pf_read_pkg::DEF_DW,
  parameter int unsigned DEPTH        = pf_read_pkg::DEF_DEPTH,
  parameter int unsigned BURST        = pf_read_pkg::DEF_BURST,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  if ((DEPTH < 2 * BURST) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_cfg
    $error("pf_read_unit: DEPTH must be a power of two and >= 2*BURST");
  end

  logic [AW-1:0] head_q, head_d;
  logic          hit, flush, pop, push, fifo_empty;
  logic [AW-1:0] flush_addr;
  logic [CW-1:0] fifo_count;
  logic [DW-1:0] head_data;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  assign hit         = req_valid_i && (req_addr_i == head_q);
  assign flush       = start_i || (req_valid_i && !hit);
  assign flush_addr  = start_i ? start_addr_i : req_addr_i;
  assign req_ready_o = hit && !start_i && !fifo_empty;
  assign pop         = req_valid_i && req_ready_o;

  always_comb begin
    head_d = head_q;
    if (flush)    head_d = flush_addr;
    else if (pop) head_d = head_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= RESET_ADDR;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      head_q      <= head_d;
      rsp_valid_q <= pop;
      if (pop) rsp_data_q <= head_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  pf_fetch_ctrl #(
    .AW(AW), .DEPTH(DEPTH), .BURST(BURST), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (flush),
    .flush_addr_i    (flush_addr),
    .fifo_count_i    (fifo_count),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .push_o          (push)
  );

  pf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (flush),
    .push_i      (push),
    .push_data_i (mem_rsp_data_i),
    .pop_i       (pop),
    .pop_data_o  (head_data),
    .count_o     (fifo_count),
    .empty_o     (fifo_empty)
  );

  p_stall_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty |-> !req_ready_o);
  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> fifo_empty);
  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> rsp_valid_o);
  p_no_spurious_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop |=> !rsp_valid_o);
  p_head_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (head_q == $past(head_q) + AW'(1)));
endmodule

// File: tb/sim_pf_read_unit.sv
module sim_pf_read_unit;
  localparam int AW = 32, DW = 32, DEPTH = 64, BURST = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, req_valid = 1'b0, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] start_addr = '0, req_addr = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic req_ready, rsp_valid, mem_req_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_req_addr;

  always #10 clk = ~clk;

  pf_read_unit #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BURST(BURST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
    .mem_req_ready_i(mem_ready), .mem_rsp_valid_i(mem_rvalid), .mem_rsp_data_i(mem_rdata));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit slow = 1'b0, done = 1'b0;

  function automatic logic [DW-1:0] word_at(logic [AW-1:0] a);
    return (a * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference model state
  int unsigned q_addr[$];
  int          q_ep[$];
  int          epoch = 0, avail = 0;
  logic [AW-1:0] exp_head = '0, exp_fetch = '0, pend_addr = '0;
  bit pend = 1'b0;

  // memory driver
  always @(posedge clk) begin
    cyc++;
    #1;
    mem_ready  = rst_n && (!slow || (cyc % 4 == 0));
    mem_rvalid = 1'b0;
    if (rst_n && q_addr.size() > 0 && (!slow || (cyc % 3 == 0))) begin
      mem_rvalid = 1'b1;
      mem_rdata  = word_at(q_addr[0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit fl, rdy, iss, pop, hs;
      fl  = start || (req_valid && req_addr != exp_head);
      rdy = req_valid && !start && (req_addr == exp_head) && (avail > 0);
      chk(req_ready == rdy, "R4/R5 req_ready", 64'(req_ready), 64'(rdy));
      iss = (DEPTH - avail - q_addr.size()) >= BURST;
      chk(mem_req_valid == iss, "R3 burst issue", 64'(mem_req_valid), 64'(iss));
      chk(avail + q_addr.size() <= DEPTH, "R3 occupancy", 64'(avail + q_addr.size()), 64'(DEPTH));
      if (mem_req_valid)
        chk(mem_req_addr == exp_fetch, "R7 burst address", 64'(mem_req_addr), 64'(exp_fetch));
      chk(rsp_valid == pend, "R8 rsp_valid", 64'(rsp_valid), 64'(pend));
      if (pend && rsp_valid)
        chk(rsp_data == word_at(pend_addr), "R2/R6 rsp_data", 64'(rsp_data), 64'(word_at(pend_addr)));
      // advance model to the coming edge
      pop = req_valid && req_ready;
      pend = pop;
      pend_addr = req_addr;
      if (mem_rvalid) begin
        int e;
        void'(q_addr.pop_front());
        e = q_ep.pop_front();
        if (!fl && e == epoch) avail++;
      end
      if (pop) begin
        if (avail > 0) avail--;
        exp_head = exp_head + 1;
      end
      hs = mem_req_valid && mem_ready;
      if (hs) for (int i = 0; i < BURST; i++) begin
        q_addr.push_back(mem_req_addr + i);
        q_ep.push_back(epoch);
      end
      if (fl) begin
        epoch++;
        avail = 0;
        exp_head  = start ? start_addr : req_addr;
        exp_fetch = exp_head;
      end else if (hs) exp_fetch = exp_fetch + BURST;
    end
  end

  task automatic rd(int unsigned a);
    req_valid = 1'b1;
    req_addr  = a;
    do @(negedge clk); while (!req_ready && !done);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd_run(int unsigned a, int n);
    for (int i = 0; i < n; i++) rd(a + i);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
    chk(!req_ready, "R1 req_ready in reset", 64'(req_ready), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_valid && mem_req_addr == 0, "R1 first burst", 64'(mem_req_addr), 0);
    @(posedge clk); #1;
    // R2/R4 sequential reads from reset address, fast memory
    rd_run(0, 40);
    idle(40);                 // R3 fill to capacity
    rd_run(40, 8);
    // R5/R6 misses with slow memory and bursts in flight
    slow = 1'b1;
    rd_run(300, 20);
    rd_run(100, 10);
    rd(50); rd(49); rd(49 + 1);
    // R7 restart before any request
    slow = 1'b0;
    start = 1'b1; start_addr = 1000;
    @(posedge clk); #1 start = 1'b0;
    idle(10);
    rd_run(1000, 20);
    // R7 start has priority over a simultaneous request
    start = 1'b1; start_addr = 2000; req_valid = 1'b1; req_addr = 1020;
    @(posedge clk); #1 start = 1'b0;
    rd_run(2000, 12);
    // R8 long run across several bursts with slow memory
    slow = 1'b1;
    rd_run(2012, 40);
    idle(5);
    finish_run();
  end
endmodule